// File: doc/BRIEF.md
# SPI Transmit Master with Programmable Inter-Word Delay

This block is a transmit-only SPI master. It sends fixed-length words taken from a small internal FIFO. The clock idles low and the receiver samples on the rising edge. Data goes out most significant bit first. Each bit changes while the clock is low, on the falling edge or when a word is loaded.

A delay count sets what happens between two queued words. With a count of zero, the next word follows the previous one with no pause, and chip-select stays low. With a count of D (D of 1 or more), the following sequence runs:

- Chip-select is released at the last falling clock edge of a word.
- Chip-select stays high for D − 0.5 clock periods.
- Chip-select then drops again.
- The first rising clock edge of the next word comes 1.5 periods after that.

The result is an idle clock gap of D + 1 periods. The same 1.5-period lead from chip-select to the first edge applies at the start of every burst.

The SPI clock period is twice the half-period setting, counted in system clocks.

Top module: `spi_dly_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and full is 0.
- R2: sclk idles low, and mosi never changes while sclk is high.
- R3: Every word is sent as DATA_W (16) bits, most significant first. The bits sampled on the sclk rising edges equal the written word; 0xAAAA is included.
- R4: The first rising sclk edge of a burst, or of a word after a delay gap, comes 3·half_div system clocks after cs_n falls.
- R5: Inside a word, each sclk high phase and each low phase lasts half_div system clocks.
- R6: With tx_delay = 0, queued words follow each other with no pause. cs_n stays low, and the time from the last falling edge of one word to the first rising edge of the next is half_div clocks.
- R7: With tx_delay = D ≥ 1 and another word queued:
  - cs_n rises in the same cycle as the last falling edge of the word.
  - cs_n stays high for (2D−1)·half_div clocks.
  - The clock gap from that falling edge to the next rising edge is (2D+2)·half_div clocks.
- R8: When the FIFO is empty at the last falling edge, cs_n rises in that same cycle and sclk stays low afterwards.
- R9: busy rises together with the first cs_n fall of a burst. It stays high through any delay gaps, and falls in the same cycle as the final cs_n rise.
- R10: The FIFO holds FIFO_DEPTH (4) words and raises full when it holds that many. A write while full is dropped, and the dropped word is never sent.
- R11: Words are sent in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | DATA_W | Word to queue |
| full | output | 1 | FIFO holds FIFO_DEPTH words |
| tx_delay | input | DLY_W | Inter-word delay in SPI clock periods |
| half_div | input | DIV_W | SPI half-period in system clocks (≥ 1) |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip-select, active low |
| busy | output | 1 | Transfer burst in progress |

## Verification
All pin outputs are registered, so the bench samples on the falling system-clock edge and stamps each change with a cycle index.

Timing checks are differences between these stamps, compared with arithmetic values:
- the 3·half_div lead from a cs_n fall to the first rising edge;
- the half_div phase lengths inside a word;
- the half_div gap between words when the delay is zero;
- the (2D−1)·half_div chip-select high time and the (2D+2)·half_div clock gap for a non-zero delay.

Checks that require events in the same cycle use equal stamps: the cs_n rise and the final falling edge, and busy dropping with the final cs_n rise.

Each scenario waits for busy to fall before any check runs. No check depends on a guessed latency.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/spi_txfifo.sv
module spi_txfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (do_wr && !do_rd)      count <= count + 1'b1;
      else if (do_rd && !do_wr) count <= count - 1'b1;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_drop_when_full_R10: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr)));
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] tcnt;
  logic [DIV_W-1:0] limit;

  assign limit = (half_div == '0) ? '0 : half_div - 1'b1;
  assign tick  = run && (tcnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) tcnt <= '0;
    else                     tcnt <= tcnt + 1'b1;
  end

  assert_tick_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    !run |-> (tcnt == '0));
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_dly_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              empty,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DLY_W-1:0]  tx_delay,
  output logic              rd_en,
  output logic              run,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int GW = DLY_W + 1;

  seq_state_t        state;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bcnt;
  logic [GW-1:0]     hcnt, gap_len;
  logic              last_bit, word_end, gap_end;

  assign run      = (state != ST_IDLE);
  assign last_bit = (bcnt == BW'(DATA_W-1));
  assign word_end = (state == ST_SHIFT) && tick && sclk && last_bit;
  assign gap_end  = (state == ST_GAP) && tick && (hcnt == gap_len - 1'b1);
  assign rd_en    = ((state == ST_IDLE) && !empty)
                 || (word_end && !empty && (tx_delay == '0))
                 || gap_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bcnt    <= '0;
      hcnt    <= '0;
      gap_len <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!empty) begin
            shreg <= rd_data;
            mosi  <= rd_data[DATA_W-1];
            bcnt  <= '0;
            hcnt  <= '0;
            cs_n  <= 1'b0;
            busy  <= 1'b1;
            state <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (hcnt == GW'(1)) begin
              hcnt  <= '0;
              state <= ST_SHIFT;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (!last_bit) begin
                bcnt  <= bcnt + 1'b1;
                mosi  <= shreg[DATA_W-2];
                shreg <= shreg << 1;
              end else if (!empty && (tx_delay == '0)) begin
                shreg <= rd_data;
                mosi  <= rd_data[DATA_W-1];
                bcnt  <= '0;
              end else if (!empty) begin
                cs_n    <= 1'b1;
                mosi    <= 1'b0;
                hcnt    <= '0;
                gap_len <= {tx_delay, 1'b0} - 1'b1;
                state   <= ST_GAP;
              end else begin
                cs_n  <= 1'b1;
                mosi  <= 1'b0;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_end) begin
              shreg <= rd_data;
              mosi  <= rd_data[DATA_W-1];
              bcnt  <= '0;
              hcnt  <= '0;
              cs_n  <= 1'b0;
              state <= ST_LEAD;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_low_when_released_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));

  assert_select_sets_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> busy);

  assert_sclk_moves_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sclk));
endmodule

// File: rtl/spi_dly_master.sv
module spi_dly_master #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DLY_W      = 4,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic [DLY_W-1:0]  tx_delay,
  input  logic [DIV_W-1:0]  half_div,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy
);
  logic              rd_en, empty, run, tick;
  logic [DATA_W-1:0] rd_data;

  spi_txfifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full)
  );

  spi_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .run(run), .half_div(half_div), .tick(tick)
  );

  spi_seq #(.DATA_W(DATA_W), .DLY_W(DLY_W)) seq_i (
    .clk(clk), .rst(rst), .tick(tick), .empty(empty), .rd_data(rd_data),
    .tx_delay(tx_delay), .rd_en(rd_en), .run(run), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  assert_busy_covers_select_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
endmodule

// File: tb/spi_dly_master_tb_top.sv
module spi_dly_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int MAXW = 8;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [3:0] tx_delay = '0;
  logic [7:0] half_div = 8'd1;
  logic full, sclk, mosi, cs_n, busy;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dly_master dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .tx_delay(tx_delay), .half_div(half_div), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .busy(busy)
  );

  // monitor state
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, p_busy = 1'b0;
  int bitn, nwords, ncsf, ncsr, nbf, t_rise, t_fall, in_word;
  int phase_err, mosi_err;
  logic [W-1:0] acc;
  logic [W-1:0] rxw [MAXW];
  int first_rise [MAXW];
  int last_fall [MAXW];
  int csf_t [MAXW];
  int csr_t [MAXW];
  int bf_t;

  task automatic mon_clear();
    bitn = 0; nwords = 0; ncsf = 0; ncsr = 0; nbf = 0; in_word = 0;
    phase_err = 0; mosi_err = 0; acc = '0; bf_t = -1;
    t_rise = 0; t_fall = 0;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (!p_sclk && sclk) begin
        if (in_word != 0 && bitn != 0 && (cyc - t_fall) != int'(half_div)) phase_err++;
        if (bitn == 0 && nwords < MAXW) first_rise[nwords] = cyc;
        acc = {acc[W-2:0], mosi};
        bitn++;
        t_rise = cyc;
      end
      if (p_sclk && !sclk) begin
        if ((cyc - t_rise) != int'(half_div)) phase_err++;
        t_fall = cyc;
        in_word = 1;
        if (bitn == W) begin
          if (nwords < MAXW) begin
            rxw[nwords] = acc;
            last_fall[nwords] = cyc;
          end
          nwords++;
          bitn = 0;
          in_word = 0;
        end
      end
      if (p_sclk && sclk && mosi != p_mosi) mosi_err++;
      if (p_cs && !cs_n && ncsf < MAXW) begin csf_t[ncsf] = cyc; ncsf++; end
      if (!p_cs && cs_n && ncsr < MAXW) begin csr_t[ncsr] = cyc; ncsr++; end
      if (p_busy && !busy) begin bf_t = cyc; nbf++; end
    end
    p_sclk <= sclk; p_cs <= cs_n; p_mosi <= mosi; p_busy <= busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!busy && k < 200) begin @(negedge clk); k++; end
    k = 0;
    while (busy && k < 20000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int sc, input int k);
    if (sc == 0) return 16'hAAAA;
    return 16'hAAAA ^ W'(k * 16'h3C5B + sc * 16'h0F1E);
  endfunction

  task automatic check_burst(input int sc, input int h, input int d, input int n,
                             input logic [W-1:0] exp_w [MAXW]);
    check(nwords == n, "R3 word count", nwords, n);
    for (int i = 0; i < n; i++)
      check(rxw[i] == exp_w[i], "R3/R11 word value", int'(rxw[i]), int'(exp_w[i]));
    check(phase_err == 0, "R5 phase length errors", phase_err, 0);
    check(mosi_err == 0, "R2 mosi change while sclk high", mosi_err, 0);
    check(first_rise[0] - csf_t[0] == 3*h, "R4 lead time", first_rise[0] - csf_t[0], 3*h);
    if (d == 0) begin
      check(ncsf == 1, "R6 single cs fall", ncsf, 1);
      for (int i = 1; i < n; i++)
        check(first_rise[i] - last_fall[i-1] == h, "R6 back-to-back gap",
              first_rise[i] - last_fall[i-1], h);
    end else begin
      check(ncsf == n, "R7 cs fall per word", ncsf, n);
      for (int i = 1; i < n; i++) begin
        check(csr_t[i-1] == last_fall[i-1], "R7 cs rise at last fall", csr_t[i-1], last_fall[i-1]);
        check(csf_t[i] - csr_t[i-1] == (2*d-1)*h, "R7 cs high time",
              csf_t[i] - csr_t[i-1], (2*d-1)*h);
        check(first_rise[i] - last_fall[i-1] == (2*d+2)*h, "R7 clock gap",
              first_rise[i] - last_fall[i-1], (2*d+2)*h);
        check(first_rise[i] - csf_t[i] == 3*h, "R4 lead after gap",
              first_rise[i] - csf_t[i], 3*h);
      end
    end
    check(ncsr >= 1 && csr_t[ncsr-1] == last_fall[n-1], "R8 final cs rise",
          csr_t[ncsr-1], last_fall[n-1]);
    check(cs_n == 1'b1 && sclk == 1'b0, "R8 idle after burst", int'({cs_n, sclk}), 2);
    check(nbf == 1 && bf_t == csr_t[ncsr-1], "R9 busy drop", bf_t, csr_t[ncsr-1]);
    if (sc < 0) $display("unused");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] ew [MAXW];
    int sc = 0;
    mon_clear();
    repeat (3) @(negedge clk);
    check(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && full == 0, "R1 reset state",
          int'({cs_n, sclk, mosi, busy, full}), 16);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1 && sclk == 0 && busy == 0, "R1 idle after reset",
          int'({cs_n, sclk, busy}), 4);

    for (int h = 1; h <= 3; h++) begin
      for (int d = 0; d <= 3; d++) begin
        half_div = 8'(h); tx_delay = 4'(d);
        @(posedge clk);
        mon_clear();
        for (int k = 0; k < 3; k++) begin
          ew[k] = pat(sc, k);
          push(ew[k]);
        end
        wait_done();
        check_burst(sc, h, d, 3, ew);
        sc++;
      end
    end

    // FIFO full and dropped write
    half_div = 8'd4; tx_delay = 4'd0;
    @(posedge clk);
    mon_clear();
    ew[0] = 16'h8001; push(ew[0]);
    repeat (3) @(negedge clk);
    for (int k = 1; k <= 4; k++) begin ew[k] = W'(16'h1234 * k); push(ew[k]); end
    check(full == 1'b1, "R10 full flag", int'(full), 1);
    push(16'hDEAD);
    wait_done();
    check(full == 1'b0, "R10 full cleared", int'(full), 0);
    check_burst(sc, 4, 0, 5, ew);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule